// File: doc/BRIEF.md
# Scan Chain Stimulus Gater for Low Shift Power

This block sits between the outputs of a test stimulus decompressor and the serial inputs of a set of scan chains. It cuts the switching activity caused by scan shifting. Before each pattern, a per-chain enable word is shifted in serially and then committed. During the shift that follows, an enabled chain receives its decompressor bit. A disabled chain receives a constant 0 for the whole pattern. The pattern generator clears the enable of any chain whose cells hold only unspecified or 0 care values. With typical patterns most chains end up disabled, so they shift a flat 0 stream.

A hold mode can also be committed with the pattern. In this mode a per-chain shadow register samples the stimulus on the first shift of each group of K shifts. It then repeats that value for the remaining K-1 shifts of the group, which gives repeat (adjacent) fill. The shadow register of a disabled chain is forced to 0. A committed hold count of 0 or 1 turns hold mode off.

Top module: `scan_chain_gater`

## Requirements
- R1: After reset, every committed enable is 0 and the shadow registers are 0, so `chain_in` is all zeros whatever `decomp_bit` carries.
- R2: With hold off, an enabled chain i presents `decomp_bit[i]` on `chain_in[i]` in the same cycle.
- R3: A chain whose committed enable is 0 presents 0 on `chain_in` in every cycle of the pattern.
- R4: Each cycle with `en_load` high shifts `en_sdata` into bit N-1 of a staging word and moves the other bits one place toward bit 0. After N loads, the first bit sent sits at bit 0 and controls chain 0.
- R5: The staging word reaches the chains only on a `pat_start` cycle. Loads during a shift, including loads in the same cycle as `shift_stb`, leave `chain_in` unchanged until the next `pat_start`.
- R6: With committed hold count K ≥ 2, count the strobes from `pat_start` as s = 0, 1, 2, ... During strobe s, `chain_in` equals the enable-masked decompressor value presented at strobe K·floor(s/K).
- R7: A committed hold count of 0 behaves exactly like a count of 1: no hold.
- R8: A disabled chain's shadow register stays 0, so hold mode never repeats a nonzero value into a disabled chain.
- R9: `hold_cnt` is sampled only on `pat_start`. Changing it mid-pattern does not change the grouping.
- R10: For the same stimulus and hold count, the number of 0/1 changes on `chain_in` across a pattern never exceeds the number with all chains enabled.
- R11: `pat_start` restarts grouping and clears the shadow registers, so the first strobe after it takes a fresh decompressor value. A strobe in the `pat_start` cycle itself is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| decomp_bit | input | NUM_CHAINS | Decompressor output, one bit per chain |
| en_load | input | 1 | Shifts `en_sdata` into the staging enable word |
| en_sdata | input | 1 | Serial enable bit |
| pat_start | input | 1 | Commits staging enables and hold count, restarts grouping |
| hold_cnt | input | HOLD_W | Shifts per hold group (0 or 1 = no hold) |
| shift_stb | input | 1 | Scan shift strobe for this cycle |
| chain_in | output | NUM_CHAINS | Stimulus driven into each scan chain input |

## Verification
Loading the next pattern's enable word can fall in the same cycle as a shift strobe of the current pattern. The bench provokes this by asserting `en_load` and `shift_stb` together on every strobe of a pattern with all chains enabled, loading an all-zero word. It judges the result by checking that every strobe still passes the decompressor bits, and that only the following `pat_start` drives the chains to 0. A second overlap, a new `pat_start` in the middle of a hold group, is checked by confirming that the next strobe takes a fresh value rather than the shadow contents.

// File: rtl/scg_pkg.sv
package scg_pkg;

  parameter int unsigned SCG_CHAINS_DEF = 8;
  parameter int unsigned SCG_HOLD_W_DEF = 4;

  // Advance a hold-group phase; wraps after (len-1), stays at 0 when hold is off.
  function automatic logic [SCG_HOLD_W_DEF-1:0] scg_phase_step(
    input logic [SCG_HOLD_W_DEF-1:0] phase,
    input logic [SCG_HOLD_W_DEF-1:0] len
  );
    if (len <= 1) begin
      return '0;
    end else if (phase == len - 1'b1) begin
      return '0;
    end else begin
      return phase + 1'b1;
    end
  endfunction

endpackage

// File: rtl/scg_enable_loader.sv
module scg_enable_loader #(
  parameter int unsigned NUM_CHAINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load_i,
  input  logic                  sdata_i,
  input  logic                  start_i,
  output logic [NUM_CHAINS-1:0] en_o
);

  logic [NUM_CHAINS-1:0] stage_q, stage_d;
  logic [NUM_CHAINS-1:0] en_q, en_d;

  always_comb begin
    stage_d = stage_q;
    if (load_i) begin
      stage_d = {sdata_i, stage_q[NUM_CHAINS-1:1]};
    end
  end

  always_comb begin
    en_d = en_q;
    if (start_i) begin
      en_d = stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      en_q    <= '0;
    end else begin
      stage_q <= stage_d;
      en_q    <= en_d;
    end
  end

  assign en_o = en_q;

  // R4
  serial_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (stage_q[NUM_CHAINS-1] == $past(sdata_i)) &&
               (stage_q[NUM_CHAINS-2:0] == $past(stage_q[NUM_CHAINS-1:1])));

  // R5
  en_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(en_q));

endmodule

// File: rtl/scg_hold_seq.sv
module scg_hold_seq #(
  parameter int unsigned HOLD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [HOLD_W-1:0] hold_cnt_i,
  input  logic              stb_i,
  output logic              fresh_o,
  output logic              capture_o
);

  logic [HOLD_W-1:0] len_q, len_d;
  logic [HOLD_W-1:0] phase_q, phase_d;
  logic              hold_on;

  assign hold_on = (len_q > 1);

  always_comb begin
    len_d   = len_q;
    phase_d = phase_q;
    if (start_i) begin
      len_d   = hold_cnt_i;
      phase_d = '0;
    end else if (stb_i) begin
      if (!hold_on) begin
        phase_d = '0;
      end else if (phase_q == len_q - 1'b1) begin
        phase_d = '0;
      end else begin
        phase_d = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      phase_q <= '0;
    end else begin
      len_q   <= len_d;
      phase_q <= phase_d;
    end
  end

  assign fresh_o   = !hold_on || (phase_q == '0);
  assign capture_o = stb_i && !start_i && (phase_q == '0);

  // R9
  hold_len_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(len_q));

  // R7
  no_hold_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q <= 1) |-> (phase_q == '0));

  // R11
  restart_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (phase_q == '0));

  // R6
  phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == '0) || (phase_q < len_q));

endmodule

// File: rtl/scg_lane.sv
module scg_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  input  logic start_i,
  input  logic stb_i,
  input  logic fresh_i,
  input  logic capture_i,
  output logic out_o
);

  logic gated;
  logic sh_q, sh_d;

  assign gated = d_i & en_i;

  always_comb begin
    sh_d = sh_q;
    if (start_i) begin
      sh_d = 1'b0;
    end else if (capture_i) begin
      sh_d = gated;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= 1'b0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign out_o = fresh_i ? gated : sh_q;

  // R8
  shadow_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !sh_q);

  // R6
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_i && !fresh_i && !start_i) |=> $stable(sh_q));

endmodule

// File: rtl/scan_chain_gater.sv
module scan_chain_gater #(
  parameter int unsigned NUM_CHAINS = scg_pkg::SCG_CHAINS_DEF,
  parameter int unsigned HOLD_W     = scg_pkg::SCG_HOLD_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CHAINS-1:0] decomp_bit,
  input  logic                  en_load,
  input  logic                  en_sdata,
  input  logic                  pat_start,
  input  logic [HOLD_W-1:0]     hold_cnt,
  input  logic                  shift_stb,
  output logic [NUM_CHAINS-1:0] chain_in
);

  logic [NUM_CHAINS-1:0] en_w;
  logic                  fresh_w;
  logic                  capture_w;

  scg_enable_loader #(.NUM_CHAINS(NUM_CHAINS)) u_loader (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (en_load),
    .sdata_i (en_sdata),
    .start_i (pat_start),
    .en_o    (en_w)
  );

  scg_hold_seq #(.HOLD_W(HOLD_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (pat_start),
    .hold_cnt_i (hold_cnt),
    .stb_i      (shift_stb),
    .fresh_o    (fresh_w),
    .capture_o  (capture_w)
  );

  for (genvar g = 0; g < NUM_CHAINS; g++) begin : g_lane
    scg_lane u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (en_w[g]),
      .d_i       (decomp_bit[g]),
      .start_i   (pat_start),
      .stb_i     (shift_stb),
      .fresh_i   (fresh_w),
      .capture_i (capture_w),
      .out_o     (chain_in[g])
    );
  end

  // R3
  disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chain_in & ~en_w) == '0);

endmodule

// File: tb/tb_scan_chain_gater.sv
module tb_scan_chain_gater;
  localparam int N  = 8;
  localparam int HW = 4;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  decomp_bit;
  logic          en_load, en_sdata, pat_start, shift_stb;
  logic [HW-1:0] hold_cnt;
  logic [N-1:0]  chain_in;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  scan_chain_gater #(.NUM_CHAINS(N), .HOLD_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .decomp_bit(decomp_bit), .en_load(en_load),
    .en_sdata(en_sdata), .pat_start(pat_start), .hold_cnt(hold_cnt),
    .shift_stb(shift_stb), .chain_in(chain_in)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  function automatic logic [N-1:0] stim(input int s);
    return N'((s * 29 + 7) ^ (s << 3) ^ (s >> 2));
  endfunction

  task automatic load_word(input logic [N-1:0] w);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      en_load = 1; en_sdata = w[i];
    end
    @(negedge clk);
    en_load = 0;
  endtask

  task automatic commit(input logic [HW-1:0] h);
    @(negedge clk);
    pat_start = 1; hold_cnt = h;
    @(posedge clk); #1;
    pat_start = 0;
  endtask

  task automatic strobe(input logic [N-1:0] d, input logic ld, input logic ldb,
                        output logic [N-1:0] got);
    @(negedge clk);
    decomp_bit = d; shift_stb = 1; en_load = ld; en_sdata = ldb;
    #5 got = chain_in;
    @(posedge clk); #1;
    shift_stb = 0; en_load = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    decomp_bit = '1;
    #2 check("R1 reset output", chain_in, '0);
  endtask

  task automatic t_pass(input logic [HW-1:0] h, input string req);
    logic [N-1:0] got;
    load_word(8'hA5);
    commit(h);
    for (int s = 0; s < 4; s++) begin
      strobe(stim(s), 0, 0, got);
      check(req, got, stim(s) & 8'hA5);
    end
    strobe(8'hFF, 0, 0, got);
    check("R3 disabled chains zero", got & 8'h5A, '0);
  endtask

  task automatic t_order();
    logic [N-1:0] got;
    load_word(8'h01);
    commit(1);
    strobe(8'hFF, 0, 0, got);
    check("R4 first bit to chain 0", got, 8'h01);
    load_word(8'h80);
    commit(1);
    strobe(8'hFF, 0, 0, got);
    check("R4 last bit to top chain", got, 8'h80);
  endtask

  task automatic t_hold(input logic [N-1:0] en, input int k);
    logic [N-1:0] got, held;
    held = '0;
    load_word(en);
    commit(HW'(k));
    for (int s = 0; s < 3 * k + 1; s++) begin
      if (s % k == 0) held = stim(s + 3) & en;
      strobe(stim(s + 3), 0, 0, got);
      check("R6 hold group value", got, held);
      check("R8 disabled chains stay zero in hold", got & ~en, '0);
    end
  endtask

  task automatic t_midload();
    logic [N-1:0] got;
    load_word(8'hFF);
    commit(1);
    for (int s = 0; s < N; s++) begin
      strobe(stim(s + 11), 1, 0, got);
      check("R5 load with strobe leaves outputs", got, stim(s + 11));
    end
    commit(1);
    strobe(8'hFF, 0, 0, got);
    check("R5 new word applies after commit", got, '0);
  endtask

  task automatic t_holdchange();
    logic [N-1:0] got, held;
    held = '0;
    load_word(8'hFF);
    commit(2);
    @(negedge clk);
    hold_cnt = 5;
    for (int s = 0; s < 6; s++) begin
      if (s % 2 == 0) held = stim(s + 20);
      strobe(stim(s + 20), 0, 0, got);
      check("R9 hold count fixed mid-pattern", got, held);
    end
  endtask

  task automatic t_restart();
    logic [N-1:0] got;
    load_word(8'hFF);
    commit(4);
    strobe(8'h0F, 0, 0, got);
    strobe(8'hF0, 0, 0, got);
    check("R6 repeat inside group", got, 8'h0F);
    commit(4);
    strobe(8'h3C, 0, 0, got);
    check("R11 restart takes fresh value", got, 8'h3C);
    strobe(8'hC3, 0, 0, got);
    check("R11 restart regroups", got, 8'h3C);
  endtask

  task automatic run_trans(input logic [N-1:0] en, output int tr);
    logic [N-1:0] got, prev;
    tr = 0; prev = '0;
    load_word(en);
    commit(2);
    for (int s = 0; s < 40; s++) begin
      strobe(stim(s * 3 + 1), 0, 0, got);
      tr += $countones(got ^ prev);
      prev = got;
    end
  endtask

  task automatic t_trans();
    int tg, tu;
    run_trans(8'h41, tg);
    run_trans(8'hFF, tu);
    checks++;
    if (tg > tu) begin
      errors++;
      $display("FAIL R10: gated transitions %0d expected at most %0d", tg, tu);
    end
    checks++;
    if (tg == 0) begin
      errors++;
      $display("FAIL R10: gated transitions %0d expected nonzero", tg);
    end
  endtask

  initial begin
    rst_n = 0; decomp_bit = '0; en_load = 0; en_sdata = 0;
    pat_start = 0; shift_stb = 0; hold_cnt = '0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_pass(1, "R2 pass-through hold 1");
    t_pass(0, "R7 hold 0 equals no hold");
    t_order();
    t_hold(8'h3C, 3);
    t_hold(8'hFF, 2);
    t_midload();
    t_holdchange();
    t_restart();
    t_trans();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule